// File: doc/BRIEF.md
# Scrolling Seven-Segment Text Driver

This block lights a row of five common-cathode seven-segment digits that share their segment lines. It needs no input other than a clock and an active-low reset. It shows a fixed built-in message, "hello 2022", which enters at the rightmost digit and moves one place to the left at each scroll step. When the last character has left the leftmost digit, the message starts again from an empty row. The loop runs forever and needs no trigger.

The digits are time-multiplexed. A prescaler splits time into digit slots. Each slot lights exactly one digit by pulling its cathode low while the wanted segments are driven high. The first clock of every slot is a dark gap, with every cathode high, so that a segment pattern never shows on the wrong digit. A second counter counts digit slots and moves the message window by one character per step. With a 100 MHz clock, the defaults give 1 kHz per digit slot (`SCAN_DIV` = 100000) and one scroll step every 300 slots, which is 300 ms (`STEP_SLOTS` = 300).

Top module: `scroll_text_driver`

## Requirements
- R1: While reset is low, and on the first clock after reset is released, every cathode is high and every segment is low. After reset, scanning starts at digit 0 and the message window starts at position 0.
- R2: At most one cathode output is low at any time (active low). Digits are served in the order 0, 1, 2, 3, 4, 0, and so on. Each digit slot lasts `SCAN_DIV` clocks.
- R3: In the first clock of each digit slot, all cathodes are high and all segments are low.
- R4: Cathode bit d drives digit position d, where position 0 is the leftmost digit and position 4 is the rightmost. At window position p, digit d shows entry p+d of the padded text. The padded text is five blanks followed by "hello 2022", and any entry past the end is blank. The window position advances by one after every `STEP_SLOTS` digit slots.
- R5: The window position counts 0 to 14 and then returns to 0, which shows an all-blank row again.
- R6: Segment bit 0 is segment a, bit 1 is b, and so on up to bit 6 for g. Bit 7 is the decimal point. The shapes are:

  | Character | Code |
  |---|---|
  | h | 0x74 |
  | e | 0x7B |
  | l | 0x30 |
  | o | 0x5C |
  | 0 | 0x3F |
  | 1 | 0x06 |
  | 2 | 0x5B |
  | 3 | 0x4F |
  | 4 | 0x66 |
  | 5 | 0x6D |
  | 6 | 0x7D |
  | 7 | 0x07 |
  | 8 | 0x7F |
  | 9 | 0x6F |

- R7: A space, any character with no shape in the list above, and any padded position all give segment code 0x00. The decimal point is never lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_o | output | 8 | Shared segment lines, active high; bit 7 is the decimal point |
| cath_n_o | output | 5 | Per-digit cathode selects, active low; bit 0 is the leftmost digit |

## Verification
The bench uses a small scan divider and step length. It compares both outputs on every clock across two full scroll loops, a reset taken mid-run, and a second loop after that reset.

It targets the following corner cases:
- **Missing dark gap.** A design that drops the gap would let two cathodes change in the same clock, so the old pattern shows on the new digit.
- **Off-by-one in the padded index.** This would make the text enter one place early or late.
- **Wrong wrap value.** This would either skip the empty row or show stale characters after the final 2.
- **Wrong or reversed segment bit order.** The shape checks catch these.

// File: rtl/scroll_text_pkg.sv
package scroll_text_pkg;

    localparam int NUM_DIG  = 5;
    localparam int SEG_W    = 8;
    localparam int MSG_LEN  = 10;
    localparam logic [8*MSG_LEN-1:0] MSG_TEXT = "hello 2022";
    localparam int PAD_LEN  = MSG_LEN + NUM_DIG;
    localparam int PTR_W    = $clog2(PAD_LEN);
    localparam int IDX_W    = $clog2(PAD_LEN + NUM_DIG);
    localparam int DIG_W    = $clog2(NUM_DIG);

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [7:0]       char_t;

    typedef struct packed {
        logic             gap;
        logic [DIG_W-1:0] dig;
    } scan_t;

    // Character at padded index: NUM_DIG leading blanks, message, trailing blanks
    function automatic char_t pad_char(input logic [IDX_W-1:0] idx);
        int pos;
        pos = int'(idx) - NUM_DIG;
        if (pos >= 0 && pos < MSG_LEN)
            return MSG_TEXT[8*(MSG_LEN-1-pos) +: 8];
        return " ";
    endfunction

    // R6 segment shapes (bit0=a .. bit6=g, bit7=dp); R7 unknown -> blank
    function automatic seg_t glyph(input char_t c);
        case (c)
            "0": return 8'h3F;
            "1": return 8'h06;
            "2": return 8'h5B;
            "3": return 8'h4F;
            "4": return 8'h66;
            "5": return 8'h6D;
            "6": return 8'h7D;
            "7": return 8'h07;
            "8": return 8'h7F;
            "9": return 8'h6F;
            "h": return 8'h74;
            "e": return 8'h7B;
            "l": return 8'h30;
            "o": return 8'h5C;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sev_scan_timer.sv
module sev_scan_timer
    import scroll_text_pkg::*;
#(
    parameter int SCAN_DIV = 100000
) (
    input  logic  clk,
    input  logic  rst_n,
    output scan_t scan,
    output logic  slot_end
);
    localparam int CNT_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic [DIG_W-1:0] dig;

    assign slot_end  = (cnt == CNT_W'(SCAN_DIV - 1));
    assign scan.gap  = (cnt == '0);
    assign scan.dig  = dig;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dig <= '0;
        end else if (slot_end) begin
            cnt <= '0;
            dig <= (dig == DIG_W'(NUM_DIG - 1)) ? '0 : dig + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    dig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig < DIG_W'(NUM_DIG));

    // R3
    dig_move_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig != $past(dig)) |-> scan.gap);

endmodule

// File: rtl/sev_scroll_ptr.sv
module sev_scroll_ptr
    import scroll_text_pkg::*;
#(
    parameter int STEP_SLOTS = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_end,
    output logic [PTR_W-1:0] ptr
);
    localparam int SLOT_W = (STEP_SLOTS > 1) ? $clog2(STEP_SLOTS) : 1;

    logic [SLOT_W-1:0] slots;
    logic              step;

    assign step = slot_end && (slots == SLOT_W'(STEP_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
            ptr   <= '0;
        end else if (step) begin
            slots <= '0;
            ptr   <= (ptr == PTR_W'(PAD_LEN - 1)) ? '0 : ptr + 1'b1;
        end else if (slot_end) begin
            slots <= slots + 1'b1;
        end
    end

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PTR_W'(PAD_LEN));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (ptr == '0 || ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/sev_digit_mux.sv
module sev_digit_mux
    import scroll_text_pkg::*;
(
    input  scan_t              scan,
    input  logic [PTR_W-1:0]   ptr,
    output seg_t               seg,
    output logic [NUM_DIG-1:0] cath_n
);
    logic [IDX_W-1:0] idx;

    assign idx = IDX_W'(ptr) + IDX_W'(scan.dig);
    assign seg = scan.gap ? '0 : glyph(pad_char(idx));

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_cath
        assign cath_n[g] = scan.gap || (scan.dig != DIG_W'(g));
    end

endmodule

// File: rtl/scroll_text_driver.sv
module scroll_text_driver
    import scroll_text_pkg::*;
#(
    parameter int SCAN_DIV   = 100000,
    parameter int STEP_SLOTS = 300
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [7:0]   seg_o,
    output logic [4:0]   cath_n_o
);
    scan_t            scan;
    logic             slot_end;
    logic [PTR_W-1:0] ptr;

    sev_scan_timer #(.SCAN_DIV(SCAN_DIV)) i_timer (
        .clk(clk), .rst_n(rst_n), .scan(scan), .slot_end(slot_end)
    );

    sev_scroll_ptr #(.STEP_SLOTS(STEP_SLOTS)) i_ptr (
        .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .ptr(ptr)
    );

    sev_digit_mux i_mux (
        .scan(scan), .ptr(ptr), .seg(seg_o), .cath_n(cath_n_o)
    );

    // R2
    one_cathode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cath_n_o) <= 1);

    // R3
    dark_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cath_n_o != 5'h1F && $past(cath_n_o) != 5'h1F) |-> $stable(cath_n_o));

    // R3
    dark_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cath_n_o == 5'h1F) |-> (seg_o == 8'h00));

    // R7
    no_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_o[7]);

endmodule

// File: tb/test_scroll_text_driver.sv
`timescale 1ns/1ps
module test_scroll_text_driver;

    localparam int D    = 3;
    localparam int STEP = 5;
    localparam int ND   = 5;
    localparam int ML   = 10;
    localparam int PL   = ML + ND;
    localparam int LOOP = PL * STEP * D;

    string msg = "hello 2022";

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] seg_o;
    logic [4:0] cath_n_o;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    scroll_text_driver #(.SCAN_DIV(D), .STEP_SLOTS(STEP)) i_scroll_text_driver (
        .clk(clk), .rst_n(rst_n), .seg_o(seg_o), .cath_n_o(cath_n_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // R6 shapes as stated in the requirement
    function automatic logic [7:0] shape(input byte c);
        case (c)
            "h": return 8'h74;
            "e": return 8'h7B;
            "l": return 8'h30;
            "o": return 8'h5C;
            "0": return 8'h3F;
            "2": return 8'h5B;
            default: return 8'h00;
        endcase
    endfunction

    // k = clock edges since reset release; sample at negedge
    task automatic expect_at(input int k);
        int  cnt, s, dig, ptr, idx;
        byte c;
        logic [7:0] es;
        cnt = k % D;
        s   = k / D;
        dig = s % ND;
        ptr = (s / STEP) % PL;
        if (cnt == 0) begin
            chk(k == 0 ? "R1 cathodes" : "R3 cathodes", {3'b0, cath_n_o}, 8'h1F);
            chk(k == 0 ? "R1 segments" : "R3 segments", seg_o, 8'h00);
        end else begin
            chk(k == 1 ? "R1 first digit" : "R2 cathodes",
                {3'b0, cath_n_o}, {3'b0, ~(5'b1 << dig)});
            idx = ptr + dig;
            c   = (idx >= ND && idx < ND + ML) ? msg[idx - ND] : " ";
            es  = shape(c);
            if (es != 0)
                chk("R4 R6 segments", seg_o, es);
            else if (ptr == 0 && s >= STEP * PL)
                chk("R5 wrap blank", seg_o, es);
            else
                chk("R7 blank", seg_o, es);
        end
    endtask

    task automatic sweep(input int n);
        expect_at(0);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            expect_at(i);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs off while reset held
        chk("R1 reset cathodes", {3'b0, cath_n_o}, 8'h1F);
        chk("R1 reset segments", seg_o, 8'h00);
        rst_n = 1'b1;
        sweep(2 * LOOP + 7);
        // reset taken mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset cathodes", {3'b0, cath_n_o}, 8'h1F);
        chk("R1 mid reset segments", seg_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        sweep(LOOP + 4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule